// File: doc/BRIEF.md
# SMBus Configuration Register Slave

This block lets a host reach a small bank of 8-bit configuration registers over a two-wire SMBus/I2C-style bus. It runs on a fast system clock and oversamples the bus clock and data lines. After its own address, the slave takes an 8-bit command code. Bit 7 of that code selects the access type. When it is set, bits 6:0 give a register offset for an indexed access of one byte or of a low/high pair. When it is clear, the access is a block transfer that starts at register 0 and carries a byte count.

The slave only pulls the data line low and never drives it high. Register contents appear on a flat parallel vector for the surrounding logic to use. A one-cycle strobe per register marks each byte that a write has just changed. Reads use the repeated-start form: the master writes the command, restarts, sends the address with the read bit, and then clocks data out of the slave. For a block read, the slave first returns the count of implemented registers and then the registers in ascending order.

Top module: `smb_cfg_slave`

## Requirements
- R1: While the synchronous reset is high, and in the cycle after it, every register reads 0x00, the data pull-low is released and no write strobe is active.
- R2: The slave acknowledges only its own 7-bit address (parameter, default 0x69). After an address mismatch it acknowledges nothing and changes no register until the next start condition.
- R3: A command byte with bit 7 = 1 selects an indexed access at offset = bits 6:0. One data byte written after such a command is stored at that offset.
- R4: In an indexed write of two data bytes, the first (low) byte goes to offset N and the second (high) byte goes to N+1. Each byte is acknowledged.
- R5: An indexed byte read (command, repeated start, address with read bit = 1) returns the register at the offset.
- R6: An indexed word read returns register N and then register N+1. The master acknowledges the first of these bytes.
- R7: Command 0x00 starts a block write. The first byte after the command is a count, and the data bytes that follow are stored from register 0 upward. Once count bytes have been stored, further data bytes are still acknowledged but are discarded.
- R8: A block read (command 0x00, repeated start, read) first returns the number of implemented registers (8 by default), then registers 0, 1, 2 and so on in ascending order, until the master NACKs.
- R9: Offsets at or beyond the number of implemented registers read as 0x00, and writes to them change nothing and raise no strobe.
- R10: The data pull-low changes only while the bus clock is low, so an acknowledge holds the line low for the whole ninth clock high period.
- R11: A master may end a block write with a stop after any complete byte. Only the bytes sent so far are stored, and the next access works normally.
- R12: Each stored byte raises exactly one strobe bit (bit i for register i) for one cycle, while the bus clock is low. Registers never change without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND with all drivers) |
| sda_pull_o | output | 1 | 1 = pull the data line low, 0 = release it |
| regs_o | output | NREG*8 | Register i on bits [8i+7:8i] |
| wr_stb_o | output | NREG | One-cycle update strobe, bit i for register i |

## Verification
The hardest case to reach is the end of a block write in its two forms: data bytes arriving after the count is used up, and a stop that cuts the transfer short before the count is reached. In both forms the strobe count and the final register image must show exactly which bytes were taken. The bench models the bus master cycle by cycle over a wired-AND data line. It sends a block whose count is smaller than its data and another whose count is larger, then reads the whole bank back through a block read. It also tests the address-mismatch path by sending well-formed write bytes after a foreign address and confirming that none of them lands.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

    localparam int BYTE_W   = 8;
    localparam int IDX_W    = 7;
    localparam int BLK_BIT  = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_BCNT,
        ST_WDAT,
        ST_RDAT,
        ST_SKIP
    } smb_state_e;

    typedef struct packed {
        logic              en;
        logic [IDX_W-1:0]  idx;
        logic [BYTE_W-1:0] data;
    } wr_req_t;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                      input logic [IDX_W-1:0]  own);
        return b[BYTE_W-1:1] == own;
    endfunction

endpackage

// File: rtl/smb_in_sync.sv
module smb_in_sync (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_p,
    output logic stop_p
);
    logic [1:0] scl_m, sda_m;
    logic       scl_q, sda_q;
    logic       scl_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_m <= 2'b11;
            sda_m <= 2'b11;
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_m <= {scl_m[0], scl_i};
            sda_m <= {sda_m[0], sda_i};
            scl_q <= scl_m[1];
            sda_q <= sda_m[1];
        end
    end

    assign scl_s    = scl_m[1];
    assign sda_s    = sda_m[1];
    assign scl_rise = scl_s & ~scl_q;
    assign scl_fall = ~scl_s & scl_q;
    assign start_p  = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_p   = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/smb_regbank.sv
module smb_regbank
    import smb_cfg_pkg::*;
#(
    parameter int NREG = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  wr_req_t                wr,
    input  logic [IDX_W-1:0]       rd_idx,
    output logic [BYTE_W-1:0]      rd_data,
    output logic [NREG*BYTE_W-1:0] regs_o,
    output logic [NREG-1:0]        stb_o
);
    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic hit;
        assign hit = wr.en && (wr.idx == IDX_W'(i));
        always_ff @(posedge clk) begin
            if (rst) begin
                regs_o[i*BYTE_W +: BYTE_W] <= '0;
                stb_o[i]                   <= 1'b0;
            end else begin
                stb_o[i] <= hit;
                if (hit) regs_o[i*BYTE_W +: BYTE_W] <= wr.data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREG; i++) begin
            if (rd_idx == IDX_W'(i)) rd_data = regs_o[i*BYTE_W +: BYTE_W];
        end
    end
endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
    import smb_cfg_pkg::*;
#(
    parameter logic [6:0] SLV_ADDR = 7'h69,
    parameter int         NREG     = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   scl_i,
    input  logic                   sda_i,
    output logic                   sda_pull_o,
    output logic [NREG*BYTE_W-1:0] regs_o,
    output logic [NREG-1:0]        wr_stb_o
);
    localparam logic [BYTE_W-1:0] CNT_BYTE = BYTE_W'(NREG);

    logic sda_s, scl_rise, scl_fall, start_p, stop_p;

    smb_in_sync u_sync (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_p(start_p), .stop_p(stop_p)
    );

    smb_state_e        state, nxt;
    logic [BYTE_W-1:0] shreg, tx, wr_left;
    logic [3:0]        bit_cnt;
    logic              in_ack, blk, cnt_pend, m_nack;
    logic [IDX_W-1:0]  ptr;
    wr_req_t           wr_req;
    logic [BYTE_W-1:0] rd_data, ld_byte;
    logic              rx_state;

    smb_regbank #(.NREG(NREG)) u_bank (
        .clk(clk), .rst(rst), .wr(wr_req), .rd_idx(ptr),
        .rd_data(rd_data), .regs_o(regs_o), .stb_o(wr_stb_o)
    );

    assign ld_byte  = cnt_pend ? CNT_BYTE : rd_data;
    assign rx_state = (state == ST_ADDR) || (state == ST_CMD) ||
                      (state == ST_BCNT) || (state == ST_WDAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            nxt        <= ST_IDLE;
            shreg      <= '0;
            tx         <= '0;
            wr_left    <= '0;
            bit_cnt    <= '0;
            in_ack     <= 1'b0;
            blk        <= 1'b0;
            cnt_pend   <= 1'b0;
            m_nack     <= 1'b0;
            ptr        <= '0;
            wr_req     <= '0;
            sda_pull_o <= 1'b0;
        end else begin
            wr_req.en <= 1'b0;
            if (start_p) begin
                state      <= ST_ADDR;
                bit_cnt    <= '0;
                in_ack     <= 1'b0;
                sda_pull_o <= 1'b0;
            end else if (stop_p) begin
                state      <= ST_IDLE;
                bit_cnt    <= '0;
                in_ack     <= 1'b0;
                sda_pull_o <= 1'b0;
            end else if (rx_state) begin
                if (scl_rise && !in_ack && bit_cnt < 4'd8) begin
                    shreg   <= {shreg[BYTE_W-2:0], sda_s};
                    bit_cnt <= bit_cnt + 4'd1;
                end
                if (scl_fall && !in_ack && bit_cnt == 4'd8) begin
                    in_ack     <= 1'b1;
                    sda_pull_o <= 1'b1;
                    case (state)
                        ST_ADDR: begin
                            if (addr_hit(shreg, SLV_ADDR)) begin
                                nxt <= shreg[0] ? ST_RDAT : ST_CMD;
                            end else begin
                                state      <= ST_SKIP;
                                in_ack     <= 1'b0;
                                sda_pull_o <= 1'b0;
                            end
                        end
                        ST_CMD: begin
                            if (shreg[BLK_BIT]) begin
                                blk      <= 1'b0;
                                cnt_pend <= 1'b0;
                                ptr      <= shreg[IDX_W-1:0];
                                nxt      <= ST_WDAT;
                            end else begin
                                blk      <= 1'b1;
                                cnt_pend <= 1'b1;
                                ptr      <= '0;
                                nxt      <= ST_BCNT;
                            end
                        end
                        ST_BCNT: begin
                            wr_left  <= shreg;
                            cnt_pend <= 1'b0;
                            nxt      <= ST_WDAT;
                        end
                        default: begin
                            if (!blk || wr_left != '0) begin
                                wr_req <= '{en: 1'b1, idx: ptr, data: shreg};
                                ptr    <= ptr + 1'b1;
                                if (blk) wr_left <= wr_left - 1'b1;
                            end
                            nxt <= ST_WDAT;
                        end
                    endcase
                end else if (scl_fall && in_ack) begin
                    in_ack  <= 1'b0;
                    bit_cnt <= '0;
                    state   <= nxt;
                    if (nxt == ST_RDAT) begin
                        tx         <= ld_byte;
                        sda_pull_o <= ~ld_byte[BYTE_W-1];
                        if (cnt_pend) cnt_pend <= 1'b0;
                        else          ptr      <= ptr + 1'b1;
                    end else begin
                        sda_pull_o <= 1'b0;
                    end
                end
            end else if (state == ST_RDAT) begin
                if (scl_rise) begin
                    if (in_ack)                m_nack  <= sda_s;
                    else if (bit_cnt < 4'd8)   bit_cnt <= bit_cnt + 4'd1;
                end
                if (scl_fall) begin
                    if (in_ack) begin
                        in_ack  <= 1'b0;
                        bit_cnt <= '0;
                        if (!m_nack) begin
                            tx         <= ld_byte;
                            sda_pull_o <= ~ld_byte[BYTE_W-1];
                            if (cnt_pend) cnt_pend <= 1'b0;
                            else          ptr      <= ptr + 1'b1;
                        end else begin
                            state      <= ST_SKIP;
                            sda_pull_o <= 1'b0;
                        end
                    end else if (bit_cnt == 4'd8) begin
                        sda_pull_o <= 1'b0;
                        in_ack     <= 1'b1;
                    end else begin
                        tx         <= {tx[BYTE_W-2:0], 1'b0};
                        sda_pull_o <= ~tx[BYTE_W-2];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/smb_cfg_chk.sv
module smb_cfg_chk #(
    parameter int NREG = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              scl_i,
    input logic              sda_pull_o,
    input logic [NREG*8-1:0] regs_o,
    input logic [NREG-1:0]   wr_stb_o
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (regs_o == '0 && !sda_pull_o && wr_stb_o == '0));

    // R10
    pull_hold_hi_chk: assert property (@(posedge clk) disable iff (rst)
        (scl_i && $past(scl_i)) |-> $stable(sda_pull_o));

    // R12
    stb_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_stb_o));

    // R12
    stb_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_stb_o != '0) |-> !scl_i);

    // R12
    regs_need_stb_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_stb_o == '0) |-> $stable(regs_o));
endmodule

bind smb_cfg_slave smb_cfg_chk #(.NREG(NREG)) u_chk (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_pull_o(sda_pull_o),
    .regs_o(regs_o), .wr_stb_o(wr_stb_o)
);

// File: tb/sim_smb_cfg_slave.sv
`timescale 1ns/1ps
module sim_smb_cfg_slave;
    localparam logic [6:0] ADDR = 7'h69;
    localparam int NREG = 8;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_pull;
    logic [NREG*8-1:0] regs;
    logic [NREG-1:0] stb;
    logic sda_line;

    assign sda_line = m_sda & ~sda_pull;

    smb_cfg_slave #(.SLV_ADDR(ADDR), .NREG(NREG)) u0 (
        .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line),
        .sda_pull_o(sda_pull), .regs_o(regs), .wr_stb_o(stb)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int failures = 0;
    int stb_total = 0;
    int nacks, unheld;
    logic [7:0] em [NREG];
    logic [7:0] wbuf [8];
    logic [7:0] rbuf [10];

    always @(negedge clk) if (!rst) stb_total += $countones(stb);

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b1; tick(2*Q);
    endtask

    task automatic put_byte(input logic [7:0] b, output logic ack);
        logic s1, s2;
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; tick(Q);
            m_scl = 1'b1; tick(2*Q);
            m_scl = 1'b0; tick(Q);
        end
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(1);
        s1 = sda_line; tick(2*Q-2);
        s2 = sda_line; tick(1);
        m_scl = 1'b0; tick(Q);
        ack = !s1;
        if (s1 != s2) unheld++;
        if (!ack) nacks++;
    endtask

    task automatic get_byte(input logic mack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            m_scl = 1'b1; tick(Q);
            b[i] = sda_line; tick(Q);
            m_scl = 1'b0;
        end
        tick(1);
        m_sda = !mack; tick(Q);
        m_scl = 1'b1; tick(2*Q);
        m_scl = 1'b0; tick(Q);
        m_sda = 1'b1;
    endtask

    task automatic write_seq(input logic [7:0] cmd, input logic use_cnt,
                             input logic [7:0] cnt, input int n);
        logic a;
        nacks = 0; unheld = 0;
        bus_start();
        put_byte({ADDR, 1'b0}, a);
        put_byte(cmd, a);
        if (use_cnt) put_byte(cnt, a);
        for (int i = 0; i < n; i++) put_byte(wbuf[i], a);
        bus_stop();
    endtask

    task automatic read_seq(input logic [7:0] cmd, input int n);
        logic a;
        nacks = 0; unheld = 0;
        bus_start();
        put_byte({ADDR, 1'b0}, a);
        put_byte(cmd, a);
        bus_start();
        put_byte({ADDR, 1'b1}, a);
        for (int i = 0; i < n; i++) get_byte(i != n-1, rbuf[i]);
        bus_stop();
    endtask

    task automatic check_all(input string tag);
        for (int i = 0; i < NREG; i++)
            chk(regs[i*8 +: 8] == em[i], tag, int'(regs[i*8 +: 8]), int'(em[i]));
    endtask

    task automatic t_reset();
        chk(regs == '0, "R1 regs after reset", 0, 0);
        chk(sda_pull == 1'b0, "R1 pull released", int'(sda_pull), 0);
        chk(stb == '0, "R1 no strobe", int'(stb), 0);
    endtask

    task automatic t_byte_write();
        int s0 = stb_total;
        wbuf[0] = 8'hA5; em[3] = 8'hA5;
        write_seq(8'h83, 1'b0, 8'h00, 1);
        chk(nacks == 0, "R3 byte write acked", nacks, 0);
        chk(unheld == 0, "R10 ack held through high", unheld, 0);
        chk(stb_total - s0 == 1, "R12 one strobe per byte", stb_total - s0, 1);
        check_all("R3 byte write image");
    endtask

    task automatic t_byte_read();
        read_seq(8'h83, 1);
        chk(nacks == 0, "R5 read setup acked", nacks, 0);
        chk(rbuf[0] == 8'hA5, "R5 byte read", int'(rbuf[0]), 8'hA5);
    endtask

    task automatic t_word_write();
        int s0 = stb_total;
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; em[5] = 8'h11; em[6] = 8'h22;
        write_seq(8'h85, 1'b0, 8'h00, 2);
        chk(nacks == 0, "R4 word write acked", nacks, 0);
        chk(stb_total - s0 == 2, "R4 two strobes", stb_total - s0, 2);
        check_all("R4 word write image");
    endtask

    task automatic t_word_read();
        read_seq(8'h85, 2);
        chk(rbuf[0] == 8'h11, "R6 word low", int'(rbuf[0]), 8'h11);
        chk(rbuf[1] == 8'h22, "R6 word high", int'(rbuf[1]), 8'h22);
    endtask

    task automatic t_mismatch();
        int s0 = stb_total;
        logic a0, a1, a2;
        nacks = 0; unheld = 0;
        bus_start();
        put_byte({7'h12, 1'b0}, a0);
        put_byte(8'h83, a1);
        put_byte(8'h5A, a2);
        bus_stop();
        chk(!a0, "R2 foreign address not acked", int'(a0), 0);
        chk(!a1 && !a2, "R2 later bytes not acked", int'({a1, a2}), 0);
        chk(stb_total == s0, "R2 no strobe", stb_total - s0, 0);
        check_all("R2 image unchanged");
    endtask

    task automatic t_block_write();
        int s0 = stb_total;
        wbuf[0] = 8'h01; wbuf[1] = 8'h02; wbuf[2] = 8'h03; wbuf[3] = 8'h04;
        em[0] = 8'h01; em[1] = 8'h02; em[2] = 8'h03;
        write_seq(8'h00, 1'b1, 8'd3, 4);
        chk(nacks == 0, "R7 all block bytes acked", nacks, 0);
        chk(stb_total - s0 == 3, "R7 count limits stores", stb_total - s0, 3);
        check_all("R7 block write image");
    endtask

    task automatic t_block_read();
        read_seq(8'h00, NREG + 1);
        chk(rbuf[0] == 8'(NREG), "R8 count first", int'(rbuf[0]), NREG);
        for (int i = 0; i < NREG; i++)
            chk(rbuf[i+1] == em[i], "R8 block data", int'(rbuf[i+1]), int'(em[i]));
    endtask

    task automatic t_out_of_range();
        int s0 = stb_total;
        wbuf[0] = 8'h77;
        write_seq(8'hA0, 1'b0, 8'h00, 1);
        chk(stb_total == s0, "R9 far write no strobe", stb_total - s0, 0);
        check_all("R9 far write image");
        read_seq(8'hA0, 1);
        chk(rbuf[0] == 8'h00, "R9 far read zero", int'(rbuf[0]), 0);
        s0 = stb_total;
        wbuf[0] = 8'h99; wbuf[1] = 8'h44; em[7] = 8'h99;
        write_seq(8'h87, 1'b0, 8'h00, 2);
        chk(stb_total - s0 == 1, "R9 word past end stores low only", stb_total - s0, 1);
        check_all("R9 word past end image");
    endtask

    task automatic t_block_early_stop();
        int s0 = stb_total;
        wbuf[0] = 8'h55; wbuf[1] = 8'h66; em[0] = 8'h55; em[1] = 8'h66;
        write_seq(8'h00, 1'b1, 8'd5, 2);
        chk(stb_total - s0 == 2, "R11 early stop strobes", stb_total - s0, 2);
        check_all("R11 early stop image");
        read_seq(8'h82, 1);
        chk(rbuf[0] == em[2], "R11 access after early stop", int'(rbuf[0]), int'(em[2]));
    endtask

    initial begin
        for (int i = 0; i < NREG; i++) em[i] = 8'h00;
        tick(5);
        rst = 1'b0;
        tick(3);
        t_reset();
        t_byte_write();
        t_byte_read();
        t_word_write();
        t_word_read();
        t_mismatch();
        t_block_write();
        t_block_read();
        t_out_of_range();
        t_block_early_stop();
        tick(10);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule